// File: doc/BRIEF.md
# Many-Valued Logic Operator Unit

This block evaluates a single logic gate over signed integers instead of single bits, so that a gate-level netlist can be run in a many-valued setting. A value's sign carries its Boolean meaning and its magnitude carries a degree of certainty. Conjunction becomes the minimum, disjunction the maximum, and inversion the arithmetic negation. Exclusive-or is built from these three. The largest positive code stands for positive infinity and its negation stands for negative infinity. Zero is not a legal value, and it raises an error flag.

Each cycle the unit takes two operands, an opcode and a threshold. One clock edge later it presents three things: the many-valued result, its Boolean projection, and a three-level projection (false, unknown, true) judged against the threshold. There is no handshake. Every cycle carries a new operation, nothing can stall it, and a result is valid exactly one cycle after its operands. Flow control therefore belongs to whoever instantiates the unit.

Top module: `mvl_op_unit`

## Requirements
- R1: Opcode 2'b00 is inversion. The result is the negation of operand A. Operand B has no effect on the result, the projections or the error flag.
- R2: Opcode 2'b01 is conjunction. The result is the smaller of the two operands, compared as signed values.
- R3: Opcode 2'b10 is disjunction. The result is the larger of the two operands, compared as signed values.
- R4: Opcode 2'b11 is exclusive-or, computed as max(min(A,-B), min(-A,B)). Its magnitude is the smaller of the two operand magnitudes, and it is positive exactly when the operands have opposite signs.
- R5: With width W, infinity is N = 2^(W-1)-1 and minus infinity is -N. The single code -2^(W-1) is read as -N on input. Negating +N gives -N, and negating -N gives +N.
- R6: A zero on A, or a zero on B under any opcode other than inversion, sets the error output for the following cycle only. In that cycle the result is -N, the Boolean output is 0 and the ternary output reads false. When the error output is low, the result is never zero.
- R7: The Boolean output is 1 exactly when the registered result is positive.
- R8: The ternary output encodes 2'b00 false, 2'b01 unknown and 2'b10 true. With threshold t it reads true when the result is at least t, false when the result is at most -t, and unknown otherwise. The code 2'b11 never appears.
- R9: All outputs are registered and follow their inputs by one clock. A synchronous reset drives the result to -N, the Boolean output to 0, the ternary output to false and the error output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 2 | Opcode: 00 invert, 01 and, 10 or, 11 xor |
| a_i | input | W | Operand A, signed |
| b_i | input | W | Operand B, signed |
| thr_i | input | W-1 | Ternary threshold, unsigned |
| res_o | output | W | Many-valued result, signed |
| bool_o | output | 1 | Boolean projection of the result |
| tern_o | output | 2 | Ternary projection of the result |
| err_o | output | 1 | Zero-operand error for the previous cycle's operation |

## Verification
The hardest cases to reach are those at the edges of the value range. One is the lone most-negative code, which must be read as minus infinity before any negation. Another is a result lying exactly on the threshold or its negative. A third is a zero on B during inversion, which must leave the error flag low. Random operands rarely hit these, so the stimulus loop mixes in the extreme codes and zero on purpose. It also sets the threshold equal to chosen operands. Directed vectors cover each boundary before the random phase.

// File: rtl/mvl_pkg.sv
`timescale 1ns/1ps
package mvl_pkg;

  typedef enum logic [1:0] {
    OP_INV = 2'b00,
    OP_AND = 2'b01,
    OP_OR  = 2'b10,
    OP_XOR = 2'b11
  } mvl_op_e;

  typedef enum logic [1:0] {
    TRI_FALSE = 2'b00,
    TRI_UNK   = 2'b01,
    TRI_TRUE  = 2'b10
  } mvl_tri_e;

endpackage

// File: rtl/mvl_canon.sv
`timescale 1ns/1ps
// Maps the one unbalanced two's-complement code onto minus infinity
// and reports an illegal zero.
module mvl_canon #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] raw_i,
  output logic signed [W-1:0] val_o,
  output logic                zero_o
);
  localparam logic signed [W-1:0] POS_INF  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_INF  = -POS_INF;
  localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    val_o  = (raw_i == MIN_CODE) ? NEG_INF : raw_i;
    zero_o = (raw_i == '0);
  end
endmodule

// File: rtl/mvl_alu.sv
`timescale 1ns/1ps
// Combinational min / max / negate evaluator on canonical operands.
module mvl_alu
  import mvl_pkg::*;
#(
  parameter int W = 8
) (
  input  mvl_op_e             op_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] res_o
);
  logic signed [W-1:0] na, nb;
  logic signed [W-1:0] and_v, or_v, lo_ab, lo_ba, xor_v;

  function automatic logic signed [W-1:0] smin(input logic signed [W-1:0] x,
                                                input logic signed [W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic signed [W-1:0] smax(input logic signed [W-1:0] x,
                                                input logic signed [W-1:0] y);
    return (x > y) ? x : y;
  endfunction

  always_comb begin
    na    = -a_i;
    nb    = -b_i;
    and_v = smin(a_i, b_i);
    or_v  = smax(a_i, b_i);
    lo_ab = smin(a_i, nb);
    lo_ba = smin(na, b_i);
    xor_v = smax(lo_ab, lo_ba);
    unique case (op_i)
      OP_INV:  res_o = na;
      OP_AND:  res_o = and_v;
      OP_OR:   res_o = or_v;
      default: res_o = xor_v;
    endcase
  end
endmodule

// File: rtl/mvl_project.sv
`timescale 1ns/1ps
// Boolean and threshold-based ternary views of a many-valued value.
module mvl_project
  import mvl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] val_i,
  input  logic [W-2:0]        thr_i,
  output logic                bool_o,
  output mvl_tri_e            tern_o
);
  logic signed [W-1:0] thr_pos, thr_neg;

  always_comb begin
    thr_pos = $signed({1'b0, thr_i});
    thr_neg = -thr_pos;
    bool_o  = (val_i > 0);
    if (val_i >= thr_pos)      tern_o = TRI_TRUE;
    else if (val_i <= thr_neg) tern_o = TRI_FALSE;
    else                       tern_o = TRI_UNK;
  end
endmodule

// File: rtl/mvl_op_unit.sv
`timescale 1ns/1ps
module mvl_op_unit
  import mvl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [1:0]          op_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic [W-2:0]        thr_i,
  output logic signed [W-1:0] res_o,
  output logic                bool_o,
  output logic [1:0]          tern_o,
  output logic                err_o
);
  localparam int NOPS = 2;
  localparam logic signed [W-1:0] POS_INF  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_INF  = -POS_INF;
  localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] raw   [NOPS];
  logic signed [W-1:0] canon [NOPS];
  logic [NOPS-1:0]     zero;

  assign raw[0] = a_i;
  assign raw[1] = b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_canon
    mvl_canon #(.W(W)) canon_i (
      .raw_i (raw[g]),
      .val_o (canon[g]),
      .zero_o(zero[g])
    );
  end

  mvl_op_e             op_e;
  logic signed [W-1:0] alu_res;
  logic                proj_bool;
  mvl_tri_e            proj_tern;
  logic                bad;

  assign op_e = mvl_op_e'(op_i);
  assign bad  = zero[0] | ((op_e != OP_INV) & zero[1]);

  mvl_alu #(.W(W)) alu_i (
    .op_i (op_e),
    .a_i  (canon[0]),
    .b_i  (canon[1]),
    .res_o(alu_res)
  );

  mvl_project #(.W(W)) proj_i (
    .val_i (alu_res),
    .thr_i (thr_i),
    .bool_o(proj_bool),
    .tern_o(proj_tern)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_o  <= NEG_INF;
      bool_o <= 1'b0;
      tern_o <= TRI_FALSE;
      err_o  <= 1'b0;
    end else begin
      err_o <= bad;
      if (bad) begin
        res_o  <= NEG_INF;
        bool_o <= 1'b0;
        tern_o <= TRI_FALSE;
      end else begin
        res_o  <= alu_res;
        bool_o <= proj_bool;
        tern_o <= proj_tern;
      end
    end
  end

  function automatic logic signed [W-1:0] mag(input logic signed [W-1:0] x);
    return (x < 0) ? -x : x;
  endfunction

  AST_INV_NEGATES: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b00 && a_i != 0 && a_i != MIN_CODE) |=> res_o == -$past(a_i)); // R1
  AST_AND_MIN: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b01 && a_i != 0 && b_i != 0 && a_i != MIN_CODE && b_i != MIN_CODE)
      |=> (res_o <= $past(a_i) && res_o <= $past(b_i))); // R2
  AST_OR_MAX: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b10 && a_i != 0 && b_i != 0 && a_i != MIN_CODE && b_i != MIN_CODE)
      |=> (res_o >= $past(a_i) && res_o >= $past(b_i))); // R3
  AST_XOR_MAG: assert property (@(posedge clk_i) disable iff (rst_i)
    (op_i == 2'b11 && a_i != 0 && b_i != 0 && a_i != MIN_CODE && b_i != MIN_CODE)
      |=> (mag(res_o) == ((mag($past(a_i)) < mag($past(b_i))) ? mag($past(a_i)) : mag($past(b_i))))); // R4
  AST_INF_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    res_o != MIN_CODE); // R5
  AST_ERR_SAFE: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (res_o == NEG_INF && !bool_o && tern_o == TRI_FALSE)); // R6
  AST_NO_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !err_o |-> res_o != 0); // R6
  AST_BOOL_SIGN: assert property (@(posedge clk_i) disable iff (rst_i)
    bool_o == (res_o > 0)); // R7
  AST_TERN_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
    tern_o != 2'b11); // R8
endmodule

// File: tb/mvl_op_unit_tb.sv
`timescale 1ns/1ps
module mvl_op_unit_tb_top;
  localparam int W = 8;
  localparam int N = 127;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] op;
  logic signed [W-1:0] a, b;
  logic [W-2:0] thr;
  logic signed [W-1:0] res;
  logic bool_v, err;
  logic [1:0] tern;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  mvl_op_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_i(rst), .op_i(op), .a_i(a), .b_i(b), .thr_i(thr),
    .res_o(res), .bool_o(bool_v), .tern_o(tern), .err_o(err)
  );

  function automatic int canon(int x);
    return (x == -128) ? -N : x;
  endfunction
  function automatic int imin(int x, int y); return (x < y) ? x : y; endfunction
  function automatic int imax(int x, int y); return (x > y) ? x : y; endfunction

  // Behavioural reference and one-cycle-later comparison.
  task automatic apply(input int o, input int av, input int bv, input int t, input string tag);
    int ca, cb, r, e_res, e_bool, e_tern, e_err;
    op = o[1:0]; a = av[W-1:0]; b = bv[W-1:0]; thr = t[W-2:0];
    ca = canon(av); cb = canon(bv);
    case (o)
      0: r = -ca;
      1: r = imin(ca, cb);
      2: r = imax(ca, cb);
      default: r = imax(imin(ca, -cb), imin(-ca, cb));
    endcase
    e_err = (av == 0 || (o != 0 && bv == 0)) ? 1 : 0;
    if (e_err == 1) begin
      e_res = -N; e_bool = 0; e_tern = 0;
    end else begin
      e_res  = r;
      e_bool = (r > 0) ? 1 : 0;
      e_tern = (r >= t) ? 2 : ((r <= -t) ? 0 : 1);
    end
    @(posedge clk); #1;
    checks++;
    if (int'(res) != e_res || int'(bool_v) != e_bool || int'(tern) != e_tern || int'(err) != e_err) begin
      fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d thr=%0d: res=%0d bool=%0d tern=%0d err=%0d expected res=%0d bool=%0d tern=%0d err=%0d",
               tag, o, av, bv, t, res, bool_v, tern, err, e_res, e_bool, e_tern, e_err);
    end
  endtask

  function automatic int pick(int unsigned r);
    case (r % 8)
      0: return 0;
      1: return -128;
      2: return 127;
      3: return -127;
      default: return int'($signed(r[15:8]));
    endcase
  endfunction

  initial begin
    rst = 1'b1; op = '0; a = 8'sd5; b = 8'sd5; thr = '0;
    repeat (2) @(posedge clk);
    #1;
    checks++; // R9 reset state
    if (res != -8'sd127 || bool_v || tern != 2'b00 || err) begin
      fails++;
      $display("FAIL R9 reset: res=%0d bool=%0d tern=%0d err=%0d expected res=-127 bool=0 tern=0 err=0",
               res, bool_v, tern, err);
    end
    rst = 1'b0;

    apply(0, 5, 0, 1, "R1");        // R1 inversion, zero on B ignored
    apply(0, -9, 77, 1, "R1");      // R1 B value irrelevant
    apply(0, -128, 3, 1, "R5");     // R5 most-negative code is minus infinity
    apply(0, 127, 3, 1, "R5");      // R5 plus infinity negates to minus infinity
    apply(1, 3, -2, 1, "R2");       // R2 and = min
    apply(1, 127, 5, 1, "R2");
    apply(2, -3, 2, 1, "R3");       // R3 or = max
    apply(2, -128, -1, 1, "R3");
    apply(3, 3, -2, 1, "R4");       // R4 xor
    apply(3, -5, -4, 1, "R4");
    apply(3, 6, 7, 1, "R4");
    apply(1, 0, 5, 1, "R6");        // R6 zero on A
    apply(2, 4, 0, 1, "R6");        // R6 zero on B
    apply(2, 4, 1, 1, "R6");        // R6 flag lasts one cycle
    apply(2, 10, 1, 10, "R8");      // R8 exactly on threshold: true
    apply(2, 9, 1, 10, "R8");       // R8 unknown
    apply(1, -10, 1, 10, "R8");     // R8 exactly on negative threshold: false
    apply(3, -4, 4, 0, "R7");       // R7 Boolean sign
    apply(3, 4, 4, 0, "R7");

    for (int i = 0; i < 3000; i++) begin
      int av, bv, t, o;
      seed = seed * 32'd1664525 + 32'd1013904223; av = pick(seed >> 8);
      seed = seed * 32'd1664525 + 32'd1013904223; bv = pick(seed >> 8);
      seed = seed * 32'd1664525 + 32'd1013904223;
      o = int'(seed[25:24]);
      t = (seed[27:26] == 2'b00 && av > 0) ? av : int'(seed[22:16]);
      apply(o, av, bv, t, "R9");    // R9 random one-cycle stream
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule